// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits behind a simple synchronous memory bus and gives a small on-chip storage array the command behaviour of a parallel flash part. Writes to the bus are not stored directly. Each write carries a command byte in its low eight bits, or a data word in the cycles that follow a command. A two-bit phase and the latched command byte decide which of these a write is. The block programs single words, erases whole sectors, runs a counted buffered write, accepts lock sequences, and keeps an 8-bit status byte. In that byte, bit 7 means ready, bit 5 means an erase error and bit 4 means a program error.

Reads depend on the latched command. They return array bytes, or the status byte copied into every device slice, or they raise a one-cycle request to a separate identifier or query responder. When the read goes to a responder, the read data is zero. A configuration input selects the byte order of multi-byte array accesses. A read-only input stops every change to the array and flags an error instead.

Top module: `flash_seq`

## Requirements
- R1: After reset the phase, the command and the status are all zero, so reads return array data. Every array byte reads 0xFF.
- R2: Read data and the request flags appear in the cycle after `rdEn`. An array read returns `accSize`+1 bytes (size code 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes), starting at `addr`. With `bigEndian` low, the byte at `addr` sits in bits 7:0. With `bigEndian` high, it sits in the most significant byte of the access. Unused upper bits are zero.
- R3: A write of 0x10 or 0x40 in phase 0 arms a program. The next write stores its data at its address and sets status bit 7. After that, reads return the status byte until a return to array read.
- R4: With `readOnly` high, the data write of a program leaves the array unchanged and sets status bits 4 and 7.
- R5: A write of 0x20 in phase 0 sets status bit 7 and fills the sector holding `addr` (aligned down to SECTOR_BYTES) with 0xFF. If `readOnly` is high, it sets bit 5 instead of erasing. The next write of 0xD0 sets bit 7 and returns to phase 0 with the command kept. A write of 0xFF, or any other byte, returns to array read.
- R6: A write of 0x60 arms a lock sequence. A following 0xD0 or 0x01 sets status bit 7 and returns to phase 0. Any other byte returns to array read.
- R7: While the command is 0x10, 0x20, 0x28, 0x40, 0x50, 0x60, 0x70 or 0xE8, a read returns the status byte in the low byte of every DEV_BYTES-wide slice that fits in the access width. 0x70 in phase 0 selects this mode without changing the phase.
- R8: A write of 0x50 in phase 0 clears the status to zero and returns to array read.
- R9: 0x90 in phase 0 selects the identifier mode: reads pulse `idReq` and return zero. 0x98 selects the query mode: reads pulse `queryReq`. Query mode stays until a 0xFF write.
- R10: In phase 0, 0x00, 0xF0, 0xFF and every byte without a meaning return to array read with the phase and the command cleared.
- R11: 0xE8 sets status bit 7. The next write gives a count N, masked to DEV_BYTES*8 bits. The N+1 writes after that each store their data and set bit 7. A 0xD0 write then completes the sequence. Any other byte there returns to array read, and the words already stored stay stored.
- R12: With `readOnly` high, each buffered data write sets status bit 4 instead of storing.
- R13: Array writes follow the same byte order as reads, chosen by `bigEndian`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| readOnly | input | 1 | Blocks array changes and sets error bits |
| bigEndian | input | 1 | Byte order of multi-byte array accesses |
| addr | input | ADDR_W | Byte address of the access |
| wrData | input | 32 | Write data; the command byte is bits 7:0 |
| accSize | input | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Read result, valid the cycle after `rdEn` |
| idReq | output | 1 | The read goes to the identifier responder |
| queryReq | output | 1 | The read goes to the query responder |

## Verification
The command decoder is driven with every byte that carries a meaning in each phase. It is also driven with bytes that carry no meaning, and with bytes that break off a started sequence. The bench then reads back and tells the modes apart by their results: a status byte copied across slices, array contents, or a responder request. Array reads and writes use all three access widths in both byte orders, so that lane swaps and width masking show up. Erases placed next to programmed data in the neighbouring sector check the sector alignment. A count above the device width checks the count masking, because a wrong mask makes the block store the confirm byte as data. Read-only runs of program, erase and buffered write check both that the array is kept and which error bits are set.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [7:0] OP_NOP      = 8'h00;
  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_ERASE_B  = 8'h28;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_CLR      = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_STAT     = 8'h70;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_BUF      = 8'hE8;
  localparam logic [7:0] OP_ALT_RST  = 8'hF0;
  localparam logic [7:0] OP_ARRAY    = 8'hFF;
  localparam logic [7:0] OP_LOCK_ALT = 8'h01;

  localparam logic [7:0] ST_READY    = 8'h80;
  localparam logic [7:0] ST_ERASEERR = 8'h20;
  localparam logic [7:0] ST_PROGERR  = 8'h10;

  typedef enum logic [1:0] {
    SEL_ARRAY  = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_IDENT  = 2'd2,
    SEL_QUERY  = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic    store;
    logic    erase;
    rd_sel_e rdSel;
  } seq_strobe_t;

  function automatic int sizeBytes(input logic [1:0] code);
    case (code)
      2'd0:    sizeBytes = 1;
      2'd1:    sizeBytes = 2;
      default: sizeBytes = 4;
    endcase
  endfunction

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             readOnly,
  input  logic [CNT_W-1:0] wrLow,
  output seq_strobe_t      strobe,
  output logic [7:0]       status,
  output logic [1:0]       phase,
  output logic [7:0]       cmd
);

  logic [1:0]       nextPhase;
  logic [7:0]       nextCmd;
  logic [7:0]       nextStatus;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic [7:0]       opByte;
  logic             goRead;

  assign opByte = wrLow[7:0];

  always_comb begin
    nextPhase    = phase;
    nextCmd      = cmd;
    nextStatus   = status;
    nextCnt      = cnt;
    goRead       = 1'b0;
    strobe.store = 1'b0;
    strobe.erase = 1'b0;
    if (wrEn) begin
      case (phase)
        2'd0: begin
          case (opByte)
            OP_NOP, OP_ALT_RST, OP_ARRAY: goRead = 1'b1;
            OP_CLR: begin
              nextStatus = 8'h00;
              goRead     = 1'b1;
            end
            OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
              nextPhase = 2'd1;
              nextCmd   = opByte;
            end
            OP_ERASE: begin
              if (readOnly) nextStatus = nextStatus | ST_ERASEERR;
              else          strobe.erase = 1'b1;
              nextStatus = nextStatus | ST_READY;
              nextPhase  = 2'd1;
              nextCmd    = opByte;
            end
            OP_BUF: begin
              nextStatus = status | ST_READY;
              nextPhase  = 2'd1;
              nextCmd    = opByte;
            end
            OP_STAT, OP_IDENT: nextCmd = opByte;
            default: goRead = 1'b1;
          endcase
        end
        2'd1: begin
          case (cmd)
            OP_PROG_A, OP_PROG_B: begin
              if (readOnly) nextStatus = nextStatus | ST_PROGERR;
              else          strobe.store = 1'b1;
              nextStatus = nextStatus | ST_READY;
              nextPhase  = 2'd0;
            end
            OP_ERASE: begin
              if (opByte == OP_CONFIRM) begin
                nextStatus = status | ST_READY;
                nextPhase  = 2'd0;
              end else goRead = 1'b1;
            end
            OP_LOCK: begin
              if (opByte == OP_CONFIRM || opByte == OP_LOCK_ALT) begin
                nextStatus = status | ST_READY;
                nextPhase  = 2'd0;
              end else goRead = 1'b1;
            end
            OP_QUERY: begin
              if (opByte == OP_ARRAY) goRead = 1'b1;
            end
            OP_BUF: begin
              nextCnt   = wrLow;
              nextPhase = 2'd2;
            end
            default: goRead = 1'b1;
          endcase
        end
        2'd2: begin
          if (cmd == OP_BUF) begin
            if (readOnly) nextStatus = nextStatus | ST_PROGERR;
            else          strobe.store = 1'b1;
            nextStatus = nextStatus | ST_READY;
            if (cnt == '0) nextPhase = 2'd3;
            nextCnt = cnt - 1'b1;
          end else goRead = 1'b1;
        end
        default: begin
          if (cmd == OP_BUF && opByte == OP_CONFIRM) begin
            nextStatus = status | ST_READY;
            nextPhase  = 2'd0;
          end else goRead = 1'b1;
        end
      endcase
      if (goRead) begin
        nextPhase = 2'd0;
        nextCmd   = OP_NOP;
      end
    end
  end

  always_comb begin
    case (cmd)
      OP_PROG_A, OP_ERASE, OP_ERASE_B, OP_PROG_B,
      OP_CLR, OP_LOCK, OP_STAT, OP_BUF: strobe.rdSel = SEL_STATUS;
      OP_IDENT:                         strobe.rdSel = SEL_IDENT;
      OP_QUERY:                         strobe.rdSel = SEL_QUERY;
      default:                          strobe.rdSel = SEL_ARRAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= 2'd0;
      cmd    <= OP_NOP;
      status <= 8'h00;
      cnt    <= '0;
    end else begin
      phase  <= nextPhase;
      cmd    <= nextCmd;
      status <= nextStatus;
      cnt    <= nextCnt;
    end
  end

endmodule

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int SECTOR_BYTES = 32,
  parameter int DEV_BYTES    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigEndian,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic [1:0]        accSize,
  input  logic              rdEn,
  input  seq_strobe_t       strobe,
  input  logic [7:0]        status,
  output logic [31:0]       rdData,
  output logic              idReq,
  output logic              queryReq
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int SEC_W = $clog2(SECTOR_BYTES);
  localparam int SLICE = (DEV_BYTES == 0) ? 2 : DEV_BYTES;
  localparam int NSLICE = 4 / SLICE;

  logic [7:0]        store [DEPTH];
  logic [ADDR_W-1:0] laneAddr [4];
  logic [7:0]        laneWr [4];
  logic [31:0]       arrayWord, statusWord, rdNext;
  int                nBytes;

  always_comb begin
    nBytes    = sizeBytes(accSize);
    arrayWord = '0;
    for (int k = 0; k < 4; k++) begin
      laneAddr[k] = addr + ADDR_W'(k);
      laneWr[k]   = bigEndian ? wrData[8*((nBytes-1-k) & 3) +: 8] : wrData[8*k +: 8];
      if (k < nBytes) begin
        if (bigEndian) arrayWord[8*((nBytes-1-k) & 3) +: 8] = store[laneAddr[k]];
        else           arrayWord[8*k +: 8] = store[laneAddr[k]];
      end
    end
  end

  always_comb begin
    statusWord = '0;
    for (int s = 0; s < NSLICE; s++) begin
      if ((s + 1) * SLICE <= nBytes) statusWord[8*SLICE*s +: 8] = status;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_ARRAY:  rdNext = arrayWord;
      SEL_STATUS: rdNext = statusWord;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= 8'hFF;
    end else if (strobe.erase) begin
      for (int i = 0; i < DEPTH; i++) begin
        if ((ADDR_W'(i) >> SEC_W) == (addr >> SEC_W)) store[i] <= 8'hFF;
      end
    end else if (strobe.store) begin
      for (int k = 0; k < 4; k++) begin
        if (k < nBytes) store[laneAddr[k]] <= laneWr[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData   <= '0;
      idReq    <= 1'b0;
      queryReq <= 1'b0;
    end else begin
      idReq    <= rdEn && strobe.rdSel == SEL_IDENT;
      queryReq <= rdEn && strobe.rdSel == SEL_QUERY;
      if (rdEn) rdData <= rdNext;
    end
  end

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int SECTOR_BYTES = 32,
  parameter int DEV_BYTES    = 1,
  parameter int BANK_BYTES   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readOnly,
  input  logic              bigEndian,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic [1:0]        accSize,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [31:0]       rdData,
  output logic              idReq,
  output logic              queryReq
);

  localparam int CNT_W = 8 * ((DEV_BYTES == 0) ? BANK_BYTES : DEV_BYTES);

  seq_strobe_t seqStrobe;
  logic [7:0]  seqStatus;
  logic [7:0]  seqCmd;
  logic [1:0]  seqPhase;

  flash_seq_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .readOnly(readOnly),
    .wrLow(wrData[CNT_W-1:0]), .strobe(seqStrobe), .status(seqStatus),
    .phase(seqPhase), .cmd(seqCmd)
  );

  flash_seq_dp #(.ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES), .DEV_BYTES(DEV_BYTES)) uDp (
    .clk(clk), .rstN(rstN), .bigEndian(bigEndian), .addr(addr), .wrData(wrData),
    .accSize(accSize), .rdEn(rdEn), .strobe(seqStrobe), .status(seqStatus),
    .rdData(rdData), .idReq(idReq), .queryReq(queryReq)
  );

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rdEn,
  input logic       readOnly,
  input logic [7:0] wrByte,
  input logic [1:0] phase,
  input logic [7:0] cmd,
  input logic [7:0] status,
  input logic       storeEn,
  input logic       idReq,
  input logic       queryReq
);

  // R9: a read goes to at most one responder
  p_one_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({idReq, queryReq}));

  // R2: a responder request only follows a read strobe
  p_req_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (idReq || queryReq) |-> $past(rdEn));

  // R3: the program data write leaves ready set and phase 0
  p_prog_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && phase == 2'd1 && (cmd == 8'h10 || cmd == 8'h40)) |=> (status[7] && phase == 2'd0));

  // R8: clear-status command empties the status and the command
  p_clear_status_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && phase == 2'd0 && wrByte == 8'h50) |=> (status == 8'h00 && cmd == 8'h00 && phase == 2'd0));

  // R8: status bits never drop except through the clear command
  p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    !($past(wrEn) && $past(phase) == 2'd0 && $past(wrByte) == 8'h50) |->
      ((status & $past(status)) == $past(status)));

  // R4: no array store while read-only
  p_ro_no_store_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(readOnly && storeEn));

endmodule

bind flash_seq flash_seq_chk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .readOnly(readOnly),
  .wrByte(wrData[7:0]), .phase(seqPhase), .cmd(seqCmd), .status(seqStatus),
  .storeEn(seqStrobe.store), .idReq(idReq), .queryReq(queryReq)
);

// File: tb/tb_flash_seq.sv
module tb_flash_seq;

  typedef struct packed {
    logic        isWr;
    logic [1:0]  size;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [1:0]  req;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 62;
  // each entry: write/read, size code, address, write data, expected read, expected {queryReq,idReq}, requirement
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd2, 8'h00, 32'h0,        32'hFFFFFFFF, 2'd0, 4'd1},  // R1 erased array
    '{1'b1, 2'd0, 8'h00, 32'h70,       32'h0,        2'd0, 4'd1},
    '{1'b0, 2'd0, 8'h00, 32'h0,        32'h00,       2'd0, 4'd1},  // R1 status zero
    '{1'b1, 2'd0, 8'h00, 32'h40,       32'h0,        2'd0, 4'd3},
    '{1'b1, 2'd0, 8'h20, 32'hA5,       32'h0,        2'd0, 4'd3},
    '{1'b1, 2'd0, 8'h10, 32'h10,       32'h0,        2'd0, 4'd3},
    '{1'b1, 2'd2, 8'h10, 32'h44332211, 32'h0,        2'd0, 4'd3},
    '{1'b0, 2'd2, 8'h00, 32'h0,        32'h80808080, 2'd0, 4'd3},  // R3 status after program
    '{1'b1, 2'd0, 8'h00, 32'hFF,       32'h0,        2'd0, 4'd2},
    '{1'b0, 2'd2, 8'h10, 32'h0,        32'h44332211, 2'd0, 4'd2},  // R2 little-endian word
    '{1'b0, 2'd0, 8'h11, 32'h0,        32'h22,       2'd0, 4'd2},
    '{1'b0, 2'd1, 8'h12, 32'h0,        32'h4433,     2'd0, 4'd2},
    '{1'b1, 2'd0, 8'h13, 32'h20,       32'h0,        2'd0, 4'd5},  // R5 erase sector 0
    '{1'b1, 2'd0, 8'h00, 32'hD0,       32'h0,        2'd0, 4'd5},
    '{1'b0, 2'd2, 8'h00, 32'h0,        32'h80808080, 2'd0, 4'd5},
    '{1'b1, 2'd0, 8'h00, 32'hFF,       32'h0,        2'd0, 4'd5},
    '{1'b0, 2'd2, 8'h10, 32'h0,        32'hFFFFFFFF, 2'd0, 4'd5},
    '{1'b0, 2'd0, 8'h20, 32'h0,        32'hA5,       2'd0, 4'd5},  // R5 next sector kept
    '{1'b1, 2'd0, 8'h00, 32'h50,       32'h0,        2'd0, 4'd8},
    '{1'b1, 2'd0, 8'h00, 32'h70,       32'h0,        2'd0, 4'd8},
    '{1'b0, 2'd0, 8'h00, 32'h0,        32'h00,       2'd0, 4'd8},  // R8 cleared
    '{1'b1, 2'd0, 8'h00, 32'h60,       32'h0,        2'd0, 4'd6},
    '{1'b1, 2'd0, 8'h00, 32'h01,       32'h0,        2'd0, 4'd6},
    '{1'b0, 2'd0, 8'h00, 32'h0,        32'h80,       2'd0, 4'd6},  // R6 lock done
    '{1'b1, 2'd0, 8'h00, 32'h60,       32'h0,        2'd0, 4'd6},
    '{1'b1, 2'd0, 8'h00, 32'h33,       32'h0,        2'd0, 4'd6},
    '{1'b0, 2'd0, 8'h20, 32'h0,        32'hA5,       2'd0, 4'd6},  // R6 bad byte to array read
    '{1'b1, 2'd0, 8'h00, 32'h70,       32'h0,        2'd0, 4'd10},
    '{1'b1, 2'd0, 8'h00, 32'h5A,       32'h0,        2'd0, 4'd10},
    '{1'b0, 2'd0, 8'h20, 32'h0,        32'hA5,       2'd0, 4'd10}, // R10 unknown byte
    '{1'b1, 2'd0, 8'h00, 32'h70,       32'h0,        2'd0, 4'd10},
    '{1'b1, 2'd0, 8'h00, 32'hF0,       32'h0,        2'd0, 4'd10},
    '{1'b0, 2'd0, 8'h20, 32'h0,        32'hA5,       2'd0, 4'd10}, // R10 0xF0
    '{1'b1, 2'd0, 8'h00, 32'h90,       32'h0,        2'd0, 4'd9},
    '{1'b0, 2'd2, 8'h00, 32'h0,        32'h0,        2'd1, 4'd9},  // R9 identifier request
    '{1'b1, 2'd0, 8'h00, 32'h98,       32'h0,        2'd0, 4'd9},
    '{1'b0, 2'd2, 8'h00, 32'h0,        32'h0,        2'd2, 4'd9},  // R9 query request
    '{1'b1, 2'd0, 8'h00, 32'h12,       32'h0,        2'd0, 4'd9},
    '{1'b0, 2'd2, 8'h04, 32'h0,        32'h0,        2'd2, 4'd9},  // R9 query held
    '{1'b1, 2'd0, 8'h00, 32'hFF,       32'h0,        2'd0, 4'd9},
    '{1'b0, 2'd0, 8'h20, 32'h0,        32'hA5,       2'd0, 4'd9},
    '{1'b1, 2'd0, 8'h00, 32'h50,       32'h0,        2'd0, 4'd11},
    '{1'b1, 2'd0, 8'h40, 32'hE8,       32'h0,        2'd0, 4'd11},
    '{1'b1, 2'd2, 8'h40, 32'h102,      32'h0,        2'd0, 4'd11}, // R11 count masked to 2
    '{1'b1, 2'd2, 8'h40, 32'h03020100, 32'h0,        2'd0, 4'd11},
    '{1'b1, 2'd2, 8'h44, 32'h07060504, 32'h0,        2'd0, 4'd11},
    '{1'b1, 2'd2, 8'h48, 32'h0B0A0908, 32'h0,        2'd0, 4'd11},
    '{1'b1, 2'd2, 8'h4C, 32'hD0,       32'h0,        2'd0, 4'd11},
    '{1'b0, 2'd0, 8'h00, 32'h0,        32'h80,       2'd0, 4'd11},
    '{1'b1, 2'd0, 8'h00, 32'hFF,       32'h0,        2'd0, 4'd11},
    '{1'b0, 2'd2, 8'h40, 32'h0,        32'h03020100, 2'd0, 4'd11},
    '{1'b0, 2'd2, 8'h48, 32'h0,        32'h0B0A0908, 2'd0, 4'd11},
    '{1'b0, 2'd2, 8'h4C, 32'h0,        32'hFFFFFFFF, 2'd0, 4'd11}, // R11 confirm not stored
    '{1'b1, 2'd0, 8'h00, 32'hE8,       32'h0,        2'd0, 4'd11},
    '{1'b1, 2'd0, 8'h00, 32'h00,       32'h0,        2'd0, 4'd11},
    '{1'b1, 2'd0, 8'h60, 32'h77,       32'h0,        2'd0, 4'd11},
    '{1'b1, 2'd0, 8'h00, 32'h33,       32'h0,        2'd0, 4'd11},
    '{1'b0, 2'd0, 8'h60, 32'h0,        32'h77,       2'd0, 4'd11}, // R11 abort keeps data
    '{1'b1, 2'd0, 8'hE0, 32'h20,       32'h0,        2'd0, 4'd5},
    '{1'b1, 2'd0, 8'h00, 32'h44,       32'h0,        2'd0, 4'd5},
    '{1'b0, 2'd2, 8'hE0, 32'h0,        32'hFFFFFFFF, 2'd0, 4'd5},  // R5 bad confirm to array read
    '{1'b1, 2'd0, 8'h00, 32'h70,       32'h0,        2'd0, 4'd7}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        readOnly = 1'b0;
  logic        bigEndian = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  accSize = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        idReq, queryReq;
  int          checkCnt = 0;
  int          failCnt = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  flash_seq dut (
    .clk(clk), .rstN(rstN), .readOnly(readOnly), .bigEndian(bigEndian),
    .addr(addr), .wrData(wrData), .accSize(accSize), .wrEn(wrEn), .rdEn(rdEn),
    .rdData(rdData), .idReq(idReq), .queryReq(queryReq)
  );

  task automatic doWr(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; accSize = sz; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRd(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] e,
                      input logic [1:0] r, input int tag);
    @(negedge clk);
    rdEn = 1'b1; accSize = sz; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    checkCnt++;
    if (rdData !== e || {queryReq, idReq} !== r) begin
      failCnt++;
      $display("FAIL R%0d: addr %h got data %h req %b, expected data %h req %b",
               tag, a, rdData, {queryReq, idReq}, e, r);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: run got stuck, expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].isWr) doWr(VEC[i].size, VEC[i].addr, VEC[i].data);
      else doRd(VEC[i].size, VEC[i].addr, VEC[i].exp, VEC[i].req, int'(VEC[i].rq));
    end
    // R7: status copied into every byte slice of the access
    doRd(2'd1, 8'h00, 32'h8080, 2'd0, 7);
    doRd(2'd0, 8'h00, 32'h80, 2'd0, 7);

    // R4: read-only program keeps the array, sets bits 4 and 7
    doWr(2'd0, 8'h00, 32'h50);
    readOnly = 1'b1;
    doWr(2'd0, 8'h10, 32'h40);
    doWr(2'd0, 8'h10, 32'h12);
    doRd(2'd0, 8'h00, 32'h90, 2'd0, 4);
    doWr(2'd0, 8'h00, 32'hFF);
    doRd(2'd0, 8'h10, 32'hFF, 2'd0, 4);

    // R5: read-only erase sets bit 5 and keeps the sector
    doWr(2'd0, 8'h00, 32'h50);
    doWr(2'd0, 8'h20, 32'h20);
    doWr(2'd0, 8'h00, 32'hD0);
    doRd(2'd0, 8'h00, 32'hA0, 2'd0, 5);
    doWr(2'd0, 8'h00, 32'hFF);
    doRd(2'd0, 8'h20, 32'hA5, 2'd0, 5);

    // R12: read-only buffered write
    doWr(2'd0, 8'h00, 32'h50);
    doWr(2'd0, 8'h60, 32'hE8);
    doWr(2'd0, 8'h60, 32'h00);
    doWr(2'd0, 8'h60, 32'h99);
    doWr(2'd0, 8'h00, 32'hD0);
    doRd(2'd0, 8'h00, 32'h90, 2'd0, 12);
    doWr(2'd0, 8'h00, 32'hFF);
    doRd(2'd0, 8'h60, 32'h77, 2'd0, 12);
    readOnly = 1'b0;

    // R13: big-endian writes, read back in both orders
    bigEndian = 1'b1;
    doWr(2'd0, 8'h00, 32'h40);
    doWr(2'd2, 8'h80, 32'h11223344);
    doWr(2'd0, 8'h00, 32'h40);
    doWr(2'd1, 8'h84, 32'hBEEF);
    doWr(2'd0, 8'h00, 32'hFF);
    bigEndian = 1'b0;
    doRd(2'd0, 8'h80, 32'h11, 2'd0, 13);
    doRd(2'd0, 8'h83, 32'h44, 2'd0, 13);
    doRd(2'd0, 8'h84, 32'hBE, 2'd0, 13);
    doRd(2'd1, 8'h82, 32'h4433, 2'd0, 2);
    bigEndian = 1'b1;
    doRd(2'd2, 8'h80, 32'h11223344, 2'd0, 2);
    doRd(2'd1, 8'h82, 32'h3344, 2'd0, 2);
    bigEndian = 1'b0;

    // R1: reset in status mode returns to array read with erased array
    doWr(2'd0, 8'h00, 32'h70);
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    doRd(2'd2, 8'h80, 32'hFFFFFFFF, 2'd0, 1);
    doWr(2'd0, 8'h00, 32'h70);
    doRd(2'd2, 8'h00, 32'h00000000, 2'd0, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule